// File: doc/BRIEF.md
# LPC Memory Cycle Header Decoder

This block sits on the target side of a four-bit multiplexed Low Pin Count bus. It watches the framing strobe and the shared nibble lines, and it finds the opening of each transfer. It keeps a transfer only when that transfer is a memory access. For an accepted transfer it records the direction and gathers the starting address, which arrives one nibble per clock. It then hands a complete header to the logic that follows in a single cycle.

Transfers meant for other targets are turned away. A transfer that does not open with the memory start code is dropped back to idle, and a one-cycle foreign-start flag reports it. A transfer that opens correctly but carries a non-memory type nibble puts the block into standby once framing has ended. The bus output enable is never asserted, because this block only decodes headers and never drives the bus.

Top module: `lpc_hdr_decoder`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next cycle shows `hdr_valid`, `hdr_write`, `standby` and `foreign_start` at 0 and `hdr_addr` at 0.
- R2: The framing strobe `frame_n` may stay low for one or more clocks. Only the nibble on `bus_nib` during the last low clock counts as the start code; nibbles on earlier low clocks have no effect.
- R3: A start code other than 4'b0000 causes no header and no standby. Instead, `foreign_start` is high for exactly the one cycle that follows the rising edge where the type nibble (the first clock with `frame_n` high) is sampled.
- R4: The type nibble is accepted only when its bits [3:2] equal 2'b01. Bit [1] gives the direction (1 = write, 0 = read) and appears on `hdr_write`. Bit [0] has no effect.
- R5: After an accepted type nibble, the next 8 clocks with `frame_n` high each carry one address nibble, most significant first. In the cycle after the edge that samples the eighth nibble, `hdr_valid` is high for one cycle, with the full 32-bit address on `hdr_addr`.
- R6: After a 4'b0000 start code, a type nibble whose bits [3:2] are not 2'b01 raises `standby` in the cycle after that type edge, and no header follows. `standby` stays high until an edge samples `frame_n` low, and it is 0 in the cycle after that edge.
- R7: If `frame_n` is sampled low while address nibbles are being collected, that transfer is abandoned with no `hdr_valid`. The low clock is treated as a new start clock.
- R8: `lad_oe` is 0 at all times.
- R9: `hdr_addr` and `hdr_write` change only in a cycle where `hdr_valid` is high; rejected and abandoned transfers leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Framing strobe from the host, active low |
| bus_nib | input | 4 | Multiplexed address/data/control nibble lines |
| hdr_valid | output | 1 | One-cycle strobe: a complete memory header is on the outputs |
| hdr_write | output | 1 | Direction of the last accepted header, 1 = write |
| hdr_addr | output | 32 | Starting address of the last accepted header |
| standby | output | 1 | High after a start-coded transfer of a non-memory type |
| foreign_start | output | 1 | One-cycle flag: a transfer opened with a non-memory start code |
| lad_oe | output | 1 | Output enable for the nibble lines, held inactive |

## Verification
If the phase state or the nibble counter is wrong, the fault shows on `hdr_valid` within the ten clocks that make up a header. The strobe then appears a cycle early or late, appears twice, or is missing, and `hdr_addr` holds nibbles that are shifted or out of order. If the start-code register latches the wrong low clock, the block swaps acceptance for `foreign_start` in the cycle after the type nibble. A stuck standby state shows as `standby` failing to drop in the first cycle after a low framing clock. Sweeping every start code and every type nibble, and walking one nibble through each address position, exposes each of these faults in the same transfer where it occurs.

// File: rtl/lpc_hdr_pkg.sv
package lpc_hdr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FRAME = 2'd1,
      PH_ADDR  = 2'd2
   } phase_e;

   localparam int unsigned NIBBLE_BITS = 4;

endpackage

// File: rtl/lpc_hdr_phase.sv
module lpc_hdr_phase
   import lpc_hdr_pkg::*;
#(
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned ADDR_NIBS  = 8,
   parameter logic [3:0]  START_CODE = 4'b0000,
   parameter logic [1:0]  MEM_TYPE   = 2'b01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic [NIB_W-1:0] nib,
   output logic             accept,
   output logic             reject,
   output logic             foreign,
   output logic             shift_en,
   output logic             last
);

   localparam int unsigned CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);
   localparam int unsigned TYPE_HI = NIB_W - 1;
   localparam int unsigned TYPE_LO = NIB_W - 2;

   phase_e           ph_q, ph_nx;
   logic [NIB_W-1:0] start_q;
   logic [CNT_W-1:0] cnt_q;
   logic             type_phase;
   logic             start_good;
   logic             type_good;

   assign type_phase = (ph_q == PH_FRAME) && frame_n;
   assign start_good = (start_q == START_CODE[NIB_W-1:0]);
   assign type_good  = (nib[TYPE_HI:TYPE_LO] == MEM_TYPE);

   assign accept   = type_phase &&  start_good &&  type_good;
   assign reject   = type_phase &&  start_good && !type_good;
   assign foreign  = type_phase && !start_good;
   assign shift_en = (ph_q == PH_ADDR) && frame_n;
   assign last     = shift_en && (cnt_q == CNT_LAST);

   always_comb begin
      ph_nx = ph_q;
      if (!frame_n) begin
         ph_nx = PH_FRAME;
      end else begin
         unique case (ph_q)
            PH_FRAME: ph_nx = accept ? PH_ADDR : PH_IDLE;
            PH_ADDR:  ph_nx = last ? PH_IDLE : PH_ADDR;
            default:  ph_nx = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         start_q <= '0;
         cnt_q   <= '0;
      end else begin
         ph_q <= ph_nx;
         if (!frame_n) begin
            start_q <= nib;
         end
         if (accept) begin
            cnt_q <= '0;
         end else if (shift_en) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lpc_hdr_addr.sv
module lpc_hdr_addr #(
   parameter int unsigned NIB_W     = 4,
   parameter int unsigned ADDR_W    = 32,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              dir_bit,
   input  logic              shift_en,
   input  logic              last,
   input  logic [NIB_W-1:0]  nib,
   output logic              hdr_valid,
   output logic              hdr_write,
   output logic [ADDR_W-1:0] hdr_addr
);

   logic [ADDR_W-1:0] sh_q;
   logic [ADDR_W-1:0] sh_nx;
   logic              dir_q;

   generate
      if (MSB_FIRST) begin : g_msb_first
         assign sh_nx = {sh_q[ADDR_W-NIB_W-1:0], nib};
      end else begin : g_lsb_first
         assign sh_nx = {nib, sh_q[ADDR_W-1:NIB_W]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q      <= '0;
         dir_q     <= 1'b0;
         hdr_valid <= 1'b0;
         hdr_write <= 1'b0;
         hdr_addr  <= '0;
      end else begin
         hdr_valid <= last;
         if (accept) begin
            dir_q <= dir_bit;
         end
         if (shift_en) begin
            sh_q <= sh_nx;
         end
         if (last) begin
            hdr_addr  <= sh_nx;
            hdr_write <= dir_q;
         end
      end
   end

endmodule

// File: rtl/lpc_hdr_status.sv
module lpc_hdr_status #(
   parameter bit FOREIGN_STICKY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic accept,
   input  logic reject,
   input  logic foreign,
   output logic standby,
   output logic foreign_start
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         standby <= 1'b0;
      end else if (!frame_n) begin
         standby <= 1'b0;
      end else if (reject) begin
         standby <= 1'b1;
      end
   end

   generate
      if (FOREIGN_STICKY) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               foreign_start <= 1'b0;
            end else if (foreign) begin
               foreign_start <= 1'b1;
            end else if (accept || reject) begin
               foreign_start <= 1'b0;
            end
         end
      end else begin : g_pulse
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               foreign_start <= 1'b0;
            end else begin
               foreign_start <= foreign;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lpc_hdr_decoder.sv
module lpc_hdr_decoder
   import lpc_hdr_pkg::*;
#(
   parameter int unsigned NIB_W          = 4,
   parameter int unsigned ADDR_W         = 32,
   parameter logic [3:0]  START_CODE     = 4'b0000,
   parameter logic [1:0]  MEM_TYPE       = 2'b01,
   parameter bit          MSB_FIRST      = 1'b1,
   parameter bit          FOREIGN_STICKY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [NIB_W-1:0]  bus_nib,
   output logic              hdr_valid,
   output logic              hdr_write,
   output logic [ADDR_W-1:0] hdr_addr,
   output logic              standby,
   output logic              foreign_start,
   output logic              lad_oe
);

   localparam int unsigned ADDR_NIBS = ADDR_W / NIB_W;
   localparam int unsigned DIR_POS   = NIB_W - 3;

   generate
      if (NIB_W != NIBBLE_BITS) begin : g_bad_nib
         $error("lpc_hdr_decoder: NIB_W must equal the bus nibble width");
      end
      if ((ADDR_W % NIB_W) != 0) begin : g_bad_addr
         $error("lpc_hdr_decoder: ADDR_W must be a whole number of nibbles");
      end
      if (ADDR_NIBS < 2) begin : g_short_addr
         $error("lpc_hdr_decoder: address must span at least two nibbles");
      end
   endgenerate

   logic accept, reject, foreign, shift_en, last;

   lpc_hdr_phase #(
      .NIB_W      (NIB_W),
      .ADDR_NIBS  (ADDR_NIBS),
      .START_CODE (START_CODE),
      .MEM_TYPE   (MEM_TYPE)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_n  (frame_n),
      .nib      (bus_nib),
      .accept   (accept),
      .reject   (reject),
      .foreign  (foreign),
      .shift_en (shift_en),
      .last     (last)
   );

   lpc_hdr_addr #(
      .NIB_W     (NIB_W),
      .ADDR_W    (ADDR_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .dir_bit   (bus_nib[DIR_POS]),
      .shift_en  (shift_en),
      .last      (last),
      .nib       (bus_nib),
      .hdr_valid (hdr_valid),
      .hdr_write (hdr_write),
      .hdr_addr  (hdr_addr)
   );

   lpc_hdr_status #(
      .FOREIGN_STICKY (FOREIGN_STICKY)
   ) u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_n       (frame_n),
      .accept        (accept),
      .reject        (reject),
      .foreign       (foreign),
      .standby       (standby),
      .foreign_start (foreign_start)
   );

   assign lad_oe = 1'b0;

endmodule

// File: rtl/lpc_hdr_decoder_chk.sv
module lpc_hdr_decoder_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic              hdr_valid,
   input logic              hdr_write,
   input logic [ADDR_W-1:0] hdr_addr,
   input logic              standby,
   input logic              foreign_start
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (!hdr_valid && !standby && !foreign_start));

   // R5
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> !hdr_valid);

   // R7
   valid_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> $past(frame_n));

   // R6
   standby_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_n |=> !standby);

   // R6
   standby_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(standby) |-> ($past(frame_n) && !hdr_valid));

   // R3
   foreign_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      foreign_start |-> (!standby && !hdr_valid));

   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hdr_addr) |-> hdr_valid);

   // R9
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hdr_write) |-> hdr_valid);

endmodule

bind lpc_hdr_decoder lpc_hdr_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .frame_n       (frame_n),
   .hdr_valid     (hdr_valid),
   .hdr_write     (hdr_write),
   .hdr_addr      (hdr_addr),
   .standby       (standby),
   .foreign_start (foreign_start)
);

// File: tb/lpc_hdr_decoder_tb.sv
module lpc_hdr_decoder_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  bus_nib = 4'h0;
   logic        hdr_valid, hdr_write, standby, foreign_start, lad_oe;
   logic [31:0] hdr_addr;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [31:0] exp_addr = 32'h0;
   logic        exp_wr = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpc_hdr_decoder u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_n       (frame_n),
      .bus_nib       (bus_nib),
      .hdr_valid     (hdr_valid),
      .hdr_write     (hdr_write),
      .hdr_addr      (hdr_addr),
      .standby       (standby),
      .foreign_start (foreign_start),
      .lad_oe        (lad_oe)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // One transfer: lowlen low clocks (pre on all but the last, start on the last),
   // a type nibble, then 8 address nibbles, most significant first.
   task automatic run_cycle(input int lowlen, input logic [3:0] pre,
                            input logic [3:0] start, input logic [3:0] typ,
                            input logic [31:0] addr, input string stag);
      bit acc, rej, frn;
      frn = (start != 4'h0);
      acc = !frn && (typ[3:2] == 2'b01);
      rej = !frn && !acc;
      for (int i = 0; i < lowlen; i++) begin
         @(negedge clk);
         frame_n = 1'b0;
         bus_nib = (i == lowlen - 1) ? start : pre;
      end
      @(negedge clk);
      frame_n = 1'b1;
      bus_nib = typ;
      @(negedge clk);
      chk(frn ? "R3" : "R6", "standby after type", {31'b0, standby}, {31'b0, rej});
      chk(frn ? "R3" : stag, "foreign_start after type",
          {31'b0, foreign_start}, {31'b0, frn});
      bus_nib = addr[31:28];
      for (int k = 1; k < 8; k++) begin
         @(negedge clk);
         if (k == 1) chk("R3", "foreign_start width", {31'b0, foreign_start}, 32'h0);
         chk("R5", "no early valid", {31'b0, hdr_valid}, 32'h0);
         bus_nib = addr[31-4*k -: 4];
      end
      @(negedge clk);
      if (acc) begin
         exp_addr = addr;
         exp_wr   = typ[1];
      end
      chk(acc ? "R5" : "R4", "hdr_valid", {31'b0, hdr_valid}, {31'b0, acc});
      chk(acc ? "R5" : "R9", "hdr_addr", hdr_addr, exp_addr);
      chk(acc ? "R4" : "R9", "hdr_write", {31'b0, hdr_write}, {31'b0, exp_wr});
      chk("R6", "standby held", {31'b0, standby}, {31'b0, rej});
      chk("R8", "lad_oe", {31'b0, lad_oe}, 32'h0);
      bus_nib = 4'h0;
      @(negedge clk);
      chk("R5", "valid one cycle", {31'b0, hdr_valid}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", {31'b0, hdr_valid}, 32'h0);
      chk("R1", "addr in reset", hdr_addr, 32'h0);
      chk("R1", "write in reset", {31'b0, hdr_write}, 32'h0);
      chk("R1", "standby in reset", {31'b0, standby}, 32'h0);
      chk("R1", "foreign in reset", {31'b0, foreign_start}, 32'h0);
      chk("R8", "lad_oe in reset", {31'b0, lad_oe}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Every type nibble after a good start; earlier low clocks carry junk (R2).
      for (int t = 0; t < 16; t++) begin
         run_cycle(1 + (t % 3), 4'(t) ^ 4'hF, 4'h0, 4'(t),
                   32'h1357_9BDF ^ (32'(t) * 32'h1111_1111), "R2");
         if (standby) begin
            @(negedge clk);
            frame_n = 1'b0;
            bus_nib = 4'h3;
            @(negedge clk);
            frame_n = 1'b1;
            chk("R6", "standby cleared by low frame", {31'b0, standby}, 32'h0);
            @(negedge clk);
         end
      end

      // Every start code with a memory-read type; earlier low clocks carry 0000 (R2).
      for (int s = 0; s < 16; s++) begin
         run_cycle(1 + (s % 2) * 2, 4'h0, 4'(s), 4'h4,
                   32'hA5C3_0F1E + 32'(s), "R2");
      end

      // Walk a nibble through every address position, both directions.
      for (int p = 0; p < 8; p++) begin
         run_cycle(1, 4'h0, 4'h0, (p % 2) ? 4'h7 : 4'h4,
                   32'h0000_000F << (4 * p), "R5");
         run_cycle(2, 4'h9, 4'h0, (p % 2) ? 4'h5 : 4'h6,
                   ~(32'h0000_000F << (4 * p)), "R5");
      end

      // Abort partway through the address (R7).
      for (int cut = 0; cut < 8; cut++) begin
         @(negedge clk);
         frame_n = 1'b0;
         bus_nib = 4'h0;
         @(negedge clk);
         frame_n = 1'b1;
         bus_nib = 4'h6;
         for (int k = 0; k < cut; k++) begin
            @(negedge clk);
            bus_nib = 4'hE;
         end
         run_cycle(1, 4'h0, 4'h0, 4'h4, 32'hCAFE_0000 + 32'(cut), "R7");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule